// File: doc/BRIEF.md
# Two-Wire Clock-Control Register Slave

This block is the serial control port of a clock generator. It watches a two-wire bus (a serial clock line and a serial data line), detects start and stop conditions, answers to one fixed 7-bit device address and gives the bus master access to a bank of seven 8-bit control registers. The block drives the data line only as an open-drain pull-down enable. The register contents are presented on a flat parallel port for the clock logic to decode.

There is no register addressing. A write transfer carries two header bytes after the address byte: a command byte and a count byte. Both are acknowledged and then thrown away. Every data byte after that goes to the next register, starting at register 0. A read transfer returns register 0 directly after the address acknowledge, then the following registers in turn. Both bus lines pass through two-flop synchronizers, and all edge detection uses the system clock.

Four strap inputs are captured while reset is held. Their inverted values appear as fixed read-only bits inside registers 1, 3 and 4. Register 6 is a read-only identifier.

Top module: `ctl2w_slave`

## Requirements
- R1: While rst_n is low the bank resets. Register 0 becomes 0x00. Register 6 reads 0x59. Every writable bit of registers 1 to 5 becomes 1. The read-only bits take inverted strap values: register 1 bit 7 = ~strap_i[2], register 3 bit 6 = ~strap_i[0], register 4 bit 3 = ~strap_i[1], register 4 bit 1 = ~strap_i[3].
- R2: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. After a stop the slave releases SDA (sda_oe = 0).
- R3: An address byte of 0xD2 (write) or 0xD3 (read), sent MSB first, is acknowledged by pulling SDA low during the ninth clock. Any other address is not acknowledged, and the bytes that follow it are neither acknowledged nor stored until the next start.
- R4: In a write, the two bytes after the address are acknowledged, and their contents change no register.
- R5: In a write, data bytes after the two header bytes are stored in registers 0, 1, 2 and onward in order, and each one is acknowledged.
- R6: In a read, register 0 is shifted out MSB first straight after the address acknowledge. Each master acknowledge moves on to the next register.
- R7: Writes to read-only bits are discarded. Read-only bits are: register 1 bit 7, register 3 bit 6, register 4 bits 3 and 1, and all of register 6. Data bytes beyond register 6 are acknowledged and discarded, and reads beyond register 6 return 0x00.
- R8: When the master does not acknowledge a read byte, the slave stops driving SDA until the next start.
- R9: A repeated start restarts address matching, and the new transfer begins again at register 0.
- R10: sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset; straps are captured while it is low |
| strap_i | input | 4 | Strap levels captured during reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_bank | output | 56 | Register i on bits [8i+7:8i] |

## Verification
The bench drives a bus master over an open-drain line model. It writes only the header bytes and then stops, which separates header bytes from data bytes. A burst of eight data bytes fills and overruns the bank, which exposes masking of the fixed bits and the handling of the bytes past the end. A foreign address separates address matching from plain byte acknowledge. Reads end with a master acknowledge, a master no-acknowledge, or a repeated start; these show that the pointer restarts at register 0 and that the line is released after the no-acknowledge.

// File: rtl/ctl2w_slave.sv
module ctl2w_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [7:0] ID_CODE  = 8'h59,
  parameter int         NREG     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        strap_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] reg_bank
);
  localparam int PW = $clog2(NREG + 1);
  localparam logic [PW-1:0] PEND = PW'(NREG);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK} st_t;

  function automatic logic [7:0] wmask(int i);
    case (i)
      1:       return 8'h7F;
      3:       return 8'hBF;
      4:       return 8'hF5;
      6:       return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  logic [3:0] strap_q;
  logic [7:0] rf [NREG];
  logic [7:0] fix [NREG];
  st_t        state;
  logic [3:0] cnt;
  logic [7:0] sr, txsr;
  logic       is_addr, rw_q, mack;
  logic [1:0] hdr_cnt;
  logic [PW-1:0] ptr, nxt_ptr;
  logic [7:0] rd_nxt;

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire start    = scl_s & scl_d & sda_d & ~sda_s;
  wire stop     = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strap_q <= strap_i;
  end

  always_comb begin
    for (int i = 0; i < NREG; i++) fix[i] = 8'h00;
    fix[1][7] = ~strap_q[2];
    fix[3][6] = ~strap_q[0];
    fix[4][3] = ~strap_q[1];
    fix[4][1] = ~strap_q[3];
    fix[NREG-1] = ID_CODE;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_bank
    assign reg_bank[g*8 +: 8] = (rf[g] & wmask(g)) | (fix[g] & ~wmask(g));
  end

  assign nxt_ptr = (ptr == PEND) ? ptr : ptr + 1'b1;
  assign rd_nxt  = (nxt_ptr < PEND) ? reg_bank[int'(nxt_ptr)*8 +: 8] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      sr      <= '0;
      txsr    <= '0;
      is_addr <= 1'b0;
      rw_q    <= 1'b0;
      mack    <= 1'b0;
      hdr_cnt <= '0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= (i == 0) ? 8'h00 : 8'hFF;
    end else if (start) begin
      state   <= S_RX;
      cnt     <= '0;
      is_addr <= 1'b1;
      hdr_cnt <= '0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
    end else if (stop) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        S_RX: begin
          if (scl_rise && cnt != 4'd8) begin
            sr  <= {sr[6:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            if (is_addr) begin
              is_addr <= 1'b0;
              if (sr[7:1] == DEV_ADDR) begin
                rw_q   <= sr[0];
                sda_oe <= 1'b1;
                state  <= S_RXACK;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              sda_oe <= 1'b1;
              state  <= S_RXACK;
              if (hdr_cnt != 2'd2) begin
                hdr_cnt <= hdr_cnt + 1'b1;
              end else begin
                if (ptr < PEND)
                  rf[ptr] <= (rf[ptr] & ~wmask(int'(ptr))) | (sr & wmask(int'(ptr)));
                ptr <= nxt_ptr;
              end
            end
          end
        end
        S_RXACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw_q) begin
              txsr   <= reg_bank[7:0];
              sda_oe <= ~reg_bank[7];
              state  <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0;
              state  <= S_TXACK;
            end else begin
              txsr   <= {txsr[6:0], 1'b0};
              sda_oe <= ~txsr[6];
              cnt    <= cnt + 1'b1;
            end
          end
        end
        S_TXACK: begin
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) begin
            cnt <= '0;
            if (mack) begin
              ptr    <= nxt_ptr;
              txsr   <= rd_nxt;
              sda_oe <= ~rd_nxt[7];
              state  <= S_TX;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: sda_oe <= 1'b0;
      endcase
    end
  end

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sda_oe);

  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R4
  bank_write_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_bank) |-> $past(state == S_RX && !is_addr && hdr_cnt == 2'd2 && !rw_q));

  // R6
  tx_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TX) |-> rw_q);

  // R8
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TXACK && scl_fall && !mack && !start && !stop) |=> (!sda_oe && state == S_IDLE));
endmodule

// File: tb/ctl2w_slave_test.sv
module ctl2w_slave_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  strap = 4'b1010;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic [55:0] reg_bank;
  wire         sda_line = sda_m & ~sda_oe;

  ctl2w_slave uut (.clk(clk), .rst_n(rst_n), .strap_i(strap), .scl_i(scl),
                   .sda_i(sda_line), .sda_oe(sda_oe), .reg_bank(reg_bank));

  always #5 clk = ~clk;

  localparam time Q = 80ns;

  typedef struct { string tag; logic [7:0] v; } item_t;
  item_t exp_q[$];
  int n_cmp = 0, n_bad = 0, oe_bad = 0;
  bit done = 0;
  logic [7:0] mdl [7];

  function automatic logic [7:0] wm(int i);
    case (i)
      1: return 8'h7F;
      3: return 8'hBF;
      4: return 8'hF5;
      6: return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic expect_v(string tag, logic [7:0] v);
    item_t it;
    it.tag = tag; it.v = v;
    exp_q.push_back(it);
  endtask

  task automatic got(logic [7:0] v);
    item_t it;
    it = exp_q.pop_front();
    n_cmp++;
    if (v !== it.v) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", it.tag, v, it.v);
    end
  endtask

  task automatic mdl_write(int i, logic [7:0] v);
    if (i < 7) mdl[i] = (mdl[i] & ~wm(i)) | (v & wm(i));
  endtask

  task automatic check_bank(string tag);
    for (int i = 0; i < 7; i++) begin
      expect_v(tag, mdl[i]);
      got(reg_bank[i*8 +: 8]);
    end
  endtask

  always @(sda_oe) if (rst_n && scl !== 1'b0) oe_bad++;

  task automatic mstart();
    sda_m = 1'b1; #Q; scl = 1'b1; #Q; sda_m = 1'b0; #Q; scl = 1'b0; #Q;
  endtask
  task automatic mstop();
    sda_m = 1'b0; #Q; scl = 1'b1; #Q; sda_m = 1'b1; #(4*Q);
  endtask
  task automatic wbit(logic b);
    sda_m = b; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
  endtask
  task automatic rbit(output logic b);
    sda_m = 1'b1; #Q; scl = 1'b1; #Q; b = sda_line; #Q; scl = 1'b0; #Q;
  endtask
  task automatic send(string tag, logic [7:0] v, logic exp_ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    expect_v(tag, {7'd0, exp_ack});
    got({7'd0, ~b});
  endtask
  task automatic recv(string tag, logic [7:0] exp_v, logic ack);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) rbit(v[i]);
    wbit(~ack);
    expect_v(tag, exp_v);
    got(v);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    mdl[0] = 8'h00; mdl[1] = 8'hFF; mdl[2] = 8'hFF; mdl[3] = 8'hFF;
    mdl[4] = 8'hF5; mdl[5] = 8'hFF; mdl[6] = 8'h59;
    #100ns; rst_n = 1'b1; #100ns;
    check_bank("R1 reset");
    expect_v("R1 sda idle", 8'h00); got({7'd0, sda_oe});

    // header only: R4
    mstart(); send("R3 wr addr", 8'hD2, 1);
    send("R4 cmd", 8'hAA, 1); send("R4 cnt", 8'h55, 1); mstop();
    check_bank("R4 header ignored");

    // R5 sequential write
    mstart(); send("R3 wr addr", 8'hD2, 1);
    send("R4 cmd", 8'h00, 1); send("R4 cnt", 8'h03, 1);
    send("R5 d0", 8'h3C, 1); mdl_write(0, 8'h3C);
    send("R5 d1", 8'h11, 1); mdl_write(1, 8'h11);
    send("R5 d2", 8'h22, 1); mdl_write(2, 8'h22);
    mstop();
    check_bank("R5 bank");
    expect_v("R2 stop release", 8'h00); got({7'd0, sda_oe});

    // R3 foreign address
    mstart(); send("R3 bad addr", 8'hA0, 0); send("R3 ignored byte", 8'h00, 0);
    send("R3 ignored byte", 8'h77, 0); mstop();
    check_bank("R3 no store");

    // R7 overrun and read-only bits
    mstart(); send("R3 wr addr", 8'hD2, 1);
    send("R4 cmd", 8'hFF, 1); send("R4 cnt", 8'hFF, 1);
    for (int i = 0; i < 8; i++) begin
      send("R7 burst ack", 8'(i + 1), 1);
      mdl_write(i, 8'(i + 1));
    end
    mstop();
    check_bank("R7 masked bank");

    // R6 read, R7 beyond end, R8 nack
    mstart(); send("R3 rd addr", 8'hD3, 1);
    for (int i = 0; i < 7; i++) recv("R6 read", mdl[i], 1);
    recv("R7 read past end", 8'h00, 0);
    recv("R8 released after nack", 8'hFF, 0);
    mstop();

    // R9 repeated start
    mstart(); send("R3 wr addr", 8'hD2, 1);
    send("R4 cmd", 8'h00, 1); send("R4 cnt", 8'h00, 1);
    send("R9 d0", 8'hC3, 1); mdl_write(0, 8'hC3);
    mstart(); send("R9 rd addr", 8'hD3, 1);
    recv("R9 restart at reg0", mdl[0], 1);
    recv("R9 reg1", mdl[1], 0);
    mstart(); send("R9 bad addr after restart", 8'hD4, 0);
    mstop();
    check_bank("R9 bank");

    expect_v("R10 oe change with scl high", 8'h00); got(8'(oe_bad));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule